// File: doc/BRIEF.md
# Dual-Rate Multiplexed Serial Port

This block is a byte-wide, full-duplex serial shift engine that serves two three-wire targets: a 48-bit configuration chain, which is built into the block, and a link to a front-panel controller. For each byte the host picks a target and supplies a byte. The engine then clocks that byte out MSB first on the chosen port and captures the returning bits at the same time. The configuration port runs at one eighth of the system clock. The panel port runs at one hundred twenty-eighth. From a 12 MHz clock these rates are 1.5 Mbit/s and 93.75 kbit/s.

The configuration chain moves its shifted contents to the parallel outputs only when the host pulses a load strobe. The chain's serial output is brought out so that it can be looped back into the configuration data-in pin. In self-test mode, each returning configuration byte is compared with the byte sent six configuration transfers earlier, and any difference sets a sticky error flag. The panel's interrupt request reaches the host through a two-stage synchronizer. The host's data-pending flag goes straight through to the panel.

Top module: `sp_dual_port`

## Requirements
- R1: The serial clock idles low. Data goes out MSB first. The data-out pin changes only while the serial clock is low: it is set up at transfer start and after each falling edge. Return data is sampled on each rising edge.
- R2: Each half period of the serial clock lasts 4 system clocks for the configuration target (target_i = 0) and 64 system clocks for the panel target (target_i = 1). This gives bit periods of 8 and 128 clocks.
- R3: The byte presented on rx_byte_o while done_o is high holds the eight data-in bits sampled during that transfer, with the first bit sampled as bit 7.
- R4: A start accepted at clock edge n raises busy_o after that edge. busy_o stays high for 16 half periods. In the cycle after busy_o falls, done_o is high for exactly one cycle.
- R5: A start, or a change of target_i, while busy_o is high is ignored. The transfer keeps its target and no new transfer follows it.
- R6: Only the port of the active target carries clock and data. The other port's clock and data-out stay low, and both ports stay low while idle.
- R7: The configuration chain is 48 bits long and shifts on each rising edge of the configuration serial clock. Its serial output is the bit shifted in 48 clocks earlier, and it is zero after reset. With the chain output looped back, each configuration transfer therefore returns the byte sent six configuration transfers earlier.
- R8: A pulse on cfg_strobe_i copies the chain to cfg_q_o on the next cycle. The byte sent first of the last six lands in bits 47:40. Shifting without a strobe leaves cfg_q_o unchanged.
- R9: rbk_err_o rises one cycle after done_o when all of the following hold: the transfer targeted the configuration chain, selftest_i is high, at least six configuration bytes have been sent since reset, and the returned byte differs from the byte sent six configuration transfers earlier. Once set, rbk_err_o stays set until reset. It never rises while selftest_i is low.
- R10: host_irq_o follows pnl_irq_i with a delay of two clock cycles.
- R11: pnl_pend_o equals host_pend_i with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a byte transfer (accepted when idle) |
| target_i | input | 1 | 0 = configuration chain, 1 = front panel |
| tx_byte_i | input | 8 | Byte to send |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at end of transfer |
| rx_byte_o | output | 8 | Received byte, valid with done_o |
| selftest_i | input | 1 | Enable readback comparison |
| rbk_err_o | output | 1 | Sticky readback mismatch flag |
| cfg_strobe_i | input | 1 | Load chain into parallel outputs |
| cfg_q_o | output | 48 | Latched configuration word |
| cfg_sck_o | output | 1 | Configuration port serial clock |
| cfg_sdo_o | output | 1 | Configuration port data out |
| cfg_sdi_i | input | 1 | Configuration port data in (readback) |
| cfg_chain_so_o | output | 1 | Serial output of the configuration chain |
| pnl_sck_o | output | 1 | Panel port serial clock |
| pnl_sdo_o | output | 1 | Panel port data out |
| pnl_sdi_i | input | 1 | Panel port data in |
| pnl_irq_i | input | 1 | Interrupt request from the panel |
| host_irq_o | output | 1 | Synchronized interrupt to the host |
| host_pend_i | input | 1 | Host has a byte waiting for the panel |
| pnl_pend_o | output | 1 | Data-pending indication to the panel |

## Verification
A bad half-period counter or a wrong divider selection shifts a serial clock edge. The error appears on the sck pin at the first toggle, within 4 or 64 cycles of the start. A latched target that drifts moves activity to the wrong port in the same cycle. A bit counter or shift register fault surfaces at the latest at the done pulse, as a misplaced pulse or a wrong byte. Faults in the chain or in the readback history stay hidden until the strobe, or until a configuration byte returns six transfers later, so the bench fills the chain completely and then drives both matching and corrupted readback.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {
    TGT_CFG = 1'b0,
    TGT_PNL = 1'b1
  } tgt_e;
endpackage

// File: rtl/sp_shift_engine.sv
module sp_shift_engine
  import sp_pkg::*;
#(
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 128,
  parameter int W        = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  tgt_e         tgt_i,
  input  logic [W-1:0] tx_i,
  input  logic         sdi_i,
  output logic         sck_o,
  output logic         sdo_o,
  output logic         busy_o,
  output logic         done_o,
  output tgt_e         tgt_o,
  output logic [W-1:0] rx_o
);
  localparam int FAST_HALF = FAST_DIV / 2;
  localparam int SLOW_HALF = SLOW_DIV / 2;
  localparam int HCW       = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
  localparam int BCW       = $clog2(W);

  logic           busy_q, sck_q, done_q;
  tgt_e           tgt_q;
  logic [HCW-1:0] hcnt_q, half_lim;
  logic [BCW-1:0] bcnt_q;
  logic [W-1:0]   tx_q, rx_q;
  logic           tick;

  assign half_lim = (tgt_q == TGT_PNL) ? HCW'(SLOW_HALF - 1) : HCW'(FAST_HALF - 1);
  assign tick     = busy_q && (hcnt_q == half_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      tgt_q  <= TGT_CFG;
      hcnt_q <= '0;
      bcnt_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          tgt_q  <= tgt_i;
          tx_q   <= tx_i;
          hcnt_q <= '0;
          bcnt_q <= '0;
          sck_q  <= 1'b0;
        end
      end else if (tick) begin
        hcnt_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[W-2:0], sdi_i};
        end else begin
          sck_q  <= 1'b0;
          tx_q   <= {tx_q[W-2:0], 1'b0};
          bcnt_q <= bcnt_q + 1'b1;
          if (bcnt_q == BCW'(W - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign sck_o  = sck_q;
  assign sdo_o  = busy_q & tx_q[W-1];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign tgt_o  = tgt_q;
  assign rx_o   = rx_q;

  p_sck_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  p_sdo_hold_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q |-> $stable(tx_q));
  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_tgt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(tgt_q));
endmodule

// File: rtl/sp_cfg_chain.sv
module sp_cfg_chain #(
  parameter int BYTES = 6,
  parameter int W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               sd_i,
  input  logic               strobe_i,
  output logic               so_o,
  output logic [BYTES*W-1:0] q_o
);
  localparam int N = BYTES * W;

  logic         sck_d;
  logic [N-1:0] chain_q, q_q;
  logic         rise;

  assign rise = sck_i & ~sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d   <= 1'b0;
      chain_q <= '0;
      q_q     <= '0;
    end else begin
      sck_d <= sck_i;
      if (rise) chain_q <= {chain_q[N-2:0], sd_i};
      if (strobe_i) q_q <= chain_q;
    end
  end

  assign so_o = chain_q[N-1];
  assign q_o  = q_q;

  p_q_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(q_q));
  p_q_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (q_q == $past(chain_q)));
endmodule

// File: rtl/sp_rbk_check.sv
module sp_rbk_check #(
  parameter int BYTES = 6,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  logic [W-1:0] tx_i,
  input  logic         done_i,
  input  logic [W-1:0] rx_i,
  input  logic         selftest_i,
  output logic         err_o
);
  localparam int CW = $clog2(BYTES + 1);

  logic [W-1:0]  hist_q [BYTES];
  logic [W-1:0]  pend_q;
  logic [CW-1:0] cnt_q;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYTES; i++) hist_q[i] <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (accept_i) pend_q <= tx_i;
      if (done_i) begin
        if (selftest_i && cnt_q == CW'(BYTES) && rx_i != hist_q[BYTES-1]) err_q <= 1'b1;
        hist_q[0] <= pend_q;
        for (int i = 1; i < BYTES; i++) hist_q[i] <= hist_q[i-1];
        if (cnt_q != CW'(BYTES)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign err_o = err_q;

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_err_needs_test_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> ($past(selftest_i) && $past(done_i)));
endmodule

// File: rtl/sp_panel_sig.sv
module sp_panel_sig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  output logic irq_o,
  input  logic pend_i,
  output logic pend_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= irq_i;
      s2_q <= s1_q;
    end
  end

  assign irq_o  = s2_q;
  assign pend_o = pend_i;
endmodule

// File: rtl/sp_dual_port.sv
module sp_dual_port
  import sp_pkg::*;
#(
  parameter int FAST_DIV  = 8,
  parameter int SLOW_DIV  = 128,
  parameter int CFG_BYTES = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   target_i,
  input  logic [7:0]             tx_byte_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [7:0]             rx_byte_o,
  input  logic                   selftest_i,
  output logic                   rbk_err_o,
  input  logic                   cfg_strobe_i,
  output logic [CFG_BYTES*8-1:0] cfg_q_o,
  output logic                   cfg_sck_o,
  output logic                   cfg_sdo_o,
  input  logic                   cfg_sdi_i,
  output logic                   cfg_chain_so_o,
  output logic                   pnl_sck_o,
  output logic                   pnl_sdo_o,
  input  logic                   pnl_sdi_i,
  input  logic                   pnl_irq_i,
  output logic                   host_irq_o,
  input  logic                   host_pend_i,
  output logic                   pnl_pend_o
);
  localparam int W = 8;

  tgt_e   tgt;
  logic   eng_sck, eng_sdo, eng_sdi, busy, done;
  logic   on_cfg, cfg_accept, cfg_done;

  assign on_cfg  = (tgt == TGT_CFG);
  assign eng_sdi = on_cfg ? cfg_sdi_i : pnl_sdi_i;

  sp_shift_engine #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .W(W)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .tgt_i  (tgt_e'(target_i)),
    .tx_i   (tx_byte_i),
    .sdi_i  (eng_sdi),
    .sck_o  (eng_sck),
    .sdo_o  (eng_sdo),
    .busy_o (busy),
    .done_o (done),
    .tgt_o  (tgt),
    .rx_o   (rx_byte_o)
  );

  assign cfg_sck_o = on_cfg & eng_sck;
  assign cfg_sdo_o = on_cfg & eng_sdo;
  assign pnl_sck_o = ~on_cfg & eng_sck;
  assign pnl_sdo_o = ~on_cfg & eng_sdo;
  assign busy_o    = busy;
  assign done_o    = done;

  sp_cfg_chain #(.BYTES(CFG_BYTES), .W(W)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sck_i   (cfg_sck_o),
    .sd_i    (cfg_sdo_o),
    .strobe_i(cfg_strobe_i),
    .so_o    (cfg_chain_so_o),
    .q_o     (cfg_q_o)
  );

  assign cfg_accept = start_i & ~busy & ~target_i;
  assign cfg_done   = done & on_cfg;

  sp_rbk_check #(.BYTES(CFG_BYTES), .W(W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (cfg_accept),
    .tx_i      (tx_byte_i),
    .done_i    (cfg_done),
    .rx_i      (rx_byte_o),
    .selftest_i(selftest_i),
    .err_o     (rbk_err_o)
  );

  sp_panel_sig u_pnl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (pnl_irq_i),
    .irq_o (host_irq_o),
    .pend_i(host_pend_i),
    .pend_o(pnl_pend_o)
  );

  p_one_port_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_sck_o && pnl_sck_o) && !(cfg_sdo_o && pnl_sdo_o));
  p_idle_ports_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(cfg_sck_o || pnl_sck_o || cfg_sdo_o || pnl_sdo_o));
endmodule

// File: tb/sim_sp_dual_port.sv
module sim_sp_dual_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, target = 1'b0, selftest = 1'b0, strobe = 1'b0;
  logic [7:0]  tx = 8'h00;
  logic        busy, done, err;
  logic [7:0]  rx;
  logic [47:0] cfg_q;
  logic        cfg_sck, cfg_sdo, cfg_sdi, chain_so;
  logic        pnl_sck, pnl_sdo, pnl_sdi = 1'b0;
  logic        pnl_irq = 1'b0, host_irq, host_pend = 1'b0, pnl_pend;
  logic [7:0]  inj = 8'h00;
  logic [7:0]  pnl_byte = 8'h00;

  int n_cmp = 0, n_bad = 0, cycles = 0;

  always #2 clk = ~clk;

  assign cfg_sdi = chain_so ^ (|inj);

  sp_dual_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .target_i(target), .tx_byte_i(tx),
    .busy_o(busy), .done_o(done), .rx_byte_o(rx), .selftest_i(selftest), .rbk_err_o(err),
    .cfg_strobe_i(strobe), .cfg_q_o(cfg_q), .cfg_sck_o(cfg_sck), .cfg_sdo_o(cfg_sdo),
    .cfg_sdi_i(cfg_sdi), .cfg_chain_so_o(chain_so), .pnl_sck_o(pnl_sck), .pnl_sdo_o(pnl_sdo),
    .pnl_sdi_i(pnl_sdi), .pnl_irq_i(pnl_irq), .host_irq_o(host_irq),
    .host_pend_i(host_pend), .pnl_pend_o(pnl_pend)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit          m_busy, m_done, m_tgt, m_err, m_err_pend;
  int          m_e, m_cnt;
  logic [7:0]  m_tx, m_rx;
  logic [7:0]  cfgq[$];
  logic [47:0] m_chain, m_q;
  bit          irq_d1, irq_d2;

  function automatic int half_of(bit t);
    return t ? 64 : 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_tgt <= 0; m_err <= 0; m_err_pend <= 0;
      m_e <= 0; m_cnt <= 0; m_tx <= 0; m_rx <= 0; m_chain <= 0; m_q <= 0;
      irq_d1 <= 0; irq_d2 <= 0;
    end else begin
      logic [7:0] exp_b;
      irq_d1 <= pnl_irq;
      irq_d2 <= irq_d1;
      m_done <= 0;
      m_err_pend <= 0;
      if (m_err_pend) m_err <= 1;
      if (strobe) m_q <= m_chain;
      if (m_busy) begin
        if (m_e + 1 == 16 * half_of(m_tgt)) begin
          m_busy <= 0;
          m_done <= 1;
          if (!m_tgt) begin
            exp_b = cfgq[0] ^ inj;
            m_rx <= exp_b;
            if (selftest && m_cnt >= 6 && exp_b != cfgq[0]) m_err_pend <= 1;
            void'(cfgq.pop_front());
            cfgq.push_back(m_tx);
            m_cnt <= m_cnt + 1;
            m_chain <= {m_chain[39:0], m_tx};
          end else begin
            m_rx <= pnl_byte;
          end
        end else begin
          m_e <= m_e + 1;
        end
      end else if (start) begin
        m_busy <= 1; m_e <= 0; m_tgt <= target; m_tx <= tx;
      end
    end
  end

  // panel-side data: next bit presented away from the sampling edge
  always @(negedge clk)
    pnl_sdi <= m_busy ? pnl_byte[7 - m_e / (2 * half_of(m_tgt))] : 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit s_act, d_act;
      int h;
      h     = half_of(m_tgt);
      s_act = m_busy && ((m_e / h) % 2 == 1);
      d_act = m_busy && m_tx[7 - (m_busy ? m_e / (2 * h) : 0)];
      chk(busy == m_busy, "R4 busy", 64'(busy), 64'(m_busy));
      chk(done == m_done, "R4 done", 64'(done), 64'(m_done));
      chk(cfg_sck == (s_act && !m_tgt), "R2 cfg sck", 64'(cfg_sck), 64'(s_act && !m_tgt));
      chk(pnl_sck == (s_act && m_tgt), "R2 pnl sck", 64'(pnl_sck), 64'(s_act && m_tgt));
      chk(cfg_sdo == (d_act && !m_tgt), "R1 R6 cfg sdo", 64'(cfg_sdo), 64'(d_act && !m_tgt));
      chk(pnl_sdo == (d_act && m_tgt), "R1 R6 pnl sdo", 64'(pnl_sdo), 64'(d_act && m_tgt));
      if (m_done) chk(rx == m_rx, m_tgt ? "R3 panel rx" : "R7 cfg readback", 64'(rx), 64'(m_rx));
      chk(cfg_q == m_q, "R8 cfg_q", 64'(cfg_q), 64'(m_q));
      chk(err == m_err, "R9 err", 64'(err), 64'(m_err));
      chk(host_irq == irq_d2, "R10 irq", 64'(host_irq), 64'(irq_d2));
      chk(pnl_pend == host_pend, "R11 pend", 64'(pnl_pend), 64'(host_pend));
    end
  end

  task automatic send(input bit t, input logic [7:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1; target = t; tx = b;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    cfgq = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    repeat (4) @(negedge clk);
    chk(busy == 0 && cfg_sck == 0 && pnl_sck == 0, "R4 R6 reset idle", 64'(busy), 64'(0));
    chk(cfg_q == 0 && err == 0, "R8 R9 reset outputs", 64'(cfg_q), 64'(0));
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R7: fill the chain, readback is zero before it is full
    send(0, 8'hA5); send(0, 8'h3C); send(0, 8'hFF);
    send(0, 8'h00); send(0, 8'h81); send(0, 8'h7E);
    @(negedge clk);
    chk(cfg_q == 48'h0, "R8 no change without strobe", 64'(cfg_q), 64'(0));
    strobe = 1; @(negedge clk); strobe = 0;
    @(negedge clk);
    chk(cfg_q == 48'hA53CFF00817E, "R8 strobe word order", 64'(cfg_q), 64'h A53CFF00817E);

    // R5: panel transfer, start/target changes during it are ignored
    pnl_byte = 8'hC3;
    host_pend = 1;
    @(negedge clk);
    start = 1; target = 1; tx = 8'h5A;
    @(negedge clk);
    start = 0;
    repeat (100) @(negedge clk);
    start = 1; target = 0; tx = 8'h11;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy == 0, "R5 start during busy ignored", 64'(busy), 64'(0));
    host_pend = 0;

    // readback without selftest, then with selftest
    send(0, 8'h12);
    selftest = 1;
    send(0, 8'h34);
    repeat (2) @(negedge clk);
    chk(err == 0, "R9 matching readback", 64'(err), 64'(0));
    selftest = 0; inj = 8'hFF;
    send(0, 8'h56);
    repeat (2) @(negedge clk);
    chk(err == 0, "R9 mismatch ignored outside selftest", 64'(err), 64'(0));
    selftest = 1;
    send(0, 8'h78);
    repeat (2) @(negedge clk);
    chk(err == 1, "R9 mismatch in selftest", 64'(err), 64'(1));
    inj = 8'h00;
    send(0, 8'h9A);
    repeat (2) @(negedge clk);
    chk(err == 1, "R9 sticky", 64'(err), 64'(1));
    selftest = 0;

    // panel again with another pattern
    pnl_byte = 8'h01;
    send(1, 8'h80);

    // R10 / R11
    pnl_irq = 1; @(negedge clk); pnl_irq = 0;
    repeat (3) @(negedge clk);
    pnl_irq = 1; host_pend = 1;
    repeat (4) @(negedge clk);
    pnl_irq = 0; host_pend = 0;
    repeat (4) @(negedge clk);

    strobe = 1; @(negedge clk); strobe = 0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule